// File: doc/BRIEF.md
# Indexed Channel Request-Enable Register

This block holds one enable bit per DMA channel and gates the hardware request lines with it. Software does not touch the enable mask by read-modify-write. It writes a channel number into a set command byte or a clear command byte, and only that one bit changes. A command byte whose weight-64 bit is 1 acts on every channel at once: it sets all bits, or it clears all bits. Command values that name no existing channel are dropped. The enable mask can also be read and written directly as a halfword.

The register port is 16 bits wide and has two byte strobes. The address selects a halfword, and bit 0 of the address is ignored. Lane 0 (strobe bit 0, data bits 7:0) is the even byte address. Lane 1 (strobe bit 1, data bits 15:8) is the odd byte address. A single halfword write with both strobes can therefore issue a set command and a clear command in the same cycle. The gated request vector is registered, so it follows the enable mask one cycle late.

Top module: `chan_enable_ctrl`

## Requirements
- R1: A write of value 0..15 in bits 6:0 of the set command byte (byte offset 0x18, lane 0) sets enable bit n and leaves all other bits unchanged.
- R2: A write of value 0..15 in bits 6:0 of the clear command byte (byte offset 0x19, lane 1) clears enable bit n and leaves all other bits unchanged.
- R3: Command values 16..63 in bits 6:0 leave the enable mask unchanged.
- R4: A set command with bit 6 equal to 1 (values 64..127) sets all 16 enable bits.
- R5: A clear command with bit 6 equal to 1 clears all 16 enable bits.
- R6: Reads of the command halfword (0x18/0x19) return zero, and so do reads of any unmapped offset.
- R7: Bit 7 of a command byte is ignored. For example, 0x85 acts exactly like 0x05.
- R8: After a synchronous active-low reset, the enable mask, `en_out` and `req_out` are all zero.
- R9: When a set and a clear command reach the same channel in the same write, the clear wins. Set and clear commands that name different channels both take effect.
- R10: `req_out[n]` equals `hw_req[n] & en[n]`, both sampled at the previous clock edge. A request whose enable bit is 0 never reaches `req_out`.
- R11: The enable mask reads and writes directly at byte offsets 0x0E (bits 7:0) and 0x0F (bits 15:8). Each byte strobe updates only its own byte.
- R12: Writes to unmapped offsets leave the enable mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, combinational read data |
| bus_addr | input | 8 | Byte address, bit 0 ignored |
| bus_be | input | 2 | Byte lane strobes |
| bus_wdata | input | 16 | Write data, lane 1 in bits 15:8 |
| bus_rdata | output | 16 | Read data, zero when not reading a mapped register |
| hw_req | input | 16 | Per-channel hardware requests |
| en_out | output | 16 | Current enable mask |
| req_out | output | 16 | Registered gated request vector |

## Verification
The hardest case to reach is a set and a clear command arriving in the same cycle. A byte-wide access can never produce it. The bench reaches it with one halfword write to 0x18 that has both strobes active. It uses this write three ways: both lanes name the same channel, the lanes name different channels, and both lanes carry global commands. Reserved command values and values with bit 7 set are checked by reading the whole mask back after the write.

// File: rtl/chen_pkg.sv
// Shared constants for the channel enable block.
// Assumes a 16-bit register port addressed by halfword with byte strobes.
package chen_pkg;
    localparam int unsigned CMD_W      = 7;      // command bits carried in a byte
    localparam int unsigned GLOBAL_BIT = 6;      // weight-64 bit selects all channels
    localparam logic [7:0]  OFS_ENABLE = 8'h0E;  // direct mask, lanes 0/1
    localparam logic [7:0]  OFS_CMD    = 8'h18;  // set on lane 0, clear on lane 1

    typedef enum logic [1:0] {
        RGN_NONE   = 2'd0,
        RGN_ENABLE = 2'd1,
        RGN_CMD    = 2'd2
    } region_e;
endpackage

// File: rtl/chen_cmd_decode.sv
// Turns one command byte into a per-channel mask.
// Bit 6 set selects every channel; values below NCH select one channel;
// everything else (reserved range) yields an empty mask. Bit 7 is ignored.
module chen_cmd_decode
    import chen_pkg::*;
#(
    parameter int unsigned NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_vld,
    input  logic [7:0]     cmd_byte,
    output logic [NCH-1:0] mask
);
    logic [CMD_W-1:0] code;
    logic             all_sel;
    logic             idx_ok;

    // Split the command into its global flag and index validity.
    always_comb begin
        code    = cmd_byte[CMD_W-1:0];
        all_sel = cmd_vld && code[GLOBAL_BIT];
        idx_ok  = cmd_vld && !code[GLOBAL_BIT] && (code < CMD_W'(NCH));
    end

    // One mask bit per channel.
    for (genvar i = 0; i < NCH; i++) begin : g_bit
        assign mask[i] = all_sel || (idx_ok && (code == CMD_W'(i)));
    end

    // A single-channel command may touch at most one channel.
    p_single_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && !cmd_byte[GLOBAL_BIT]) |-> $onehot0(mask));

    // Reserved codes produce no mask bits.
    p_reserved_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_byte[GLOBAL_BIT] && cmd_byte[CMD_W-1:0] >= CMD_W'(NCH)) |-> (mask == '0));
endmodule

// File: rtl/chen_enable_reg.sv
// Holds the enable mask. A direct byte write is applied first,
// then set commands, then clear commands, so a clear beats a set.
// Assumes direct writes and commands never coincide (different halfwords).
module chen_enable_reg #(
    parameter int unsigned NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     lane_wr,
    input  logic [15:0]    wdata,
    input  logic [NCH-1:0] set_mask,
    input  logic [NCH-1:0] clr_mask,
    output logic [NCH-1:0] en_q
);
    logic [NCH-1:0] direct_val;
    logic [NCH-1:0] en_d;

    // Replace bits whose byte lane is being written directly.
    for (genvar i = 0; i < NCH; i++) begin : g_lane
        localparam int unsigned LANE = i / 8;
        assign direct_val[i] = lane_wr[LANE] ? wdata[i] : en_q[i];
    end

    // Apply set then clear so clear has priority.
    always_comb begin
        en_d = (direct_val | set_mask) & ~clr_mask;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask == '0 && clr_mask == '0 && lane_wr == 2'b00) |=> $stable(en_q));

    p_set_applies_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0 && clr_mask == '0) |=> ((en_q & $past(set_mask)) == $past(set_mask)));

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((en_q & $past(clr_mask)) == '0));

    p_reset_zero_r8: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0));
endmodule

// File: rtl/chen_req_gate.sv
// Registers the hardware requests masked by the enable bits.
// Assumes hw_req is synchronous to clk.
module chen_req_gate #(
    parameter int unsigned NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hw_req,
    input  logic [NCH-1:0] en,
    output logic [NCH-1:0] req_q
);
    // Gated request register.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= hw_req & en;
    end

    p_no_disabled_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_q & ~$past(en)) == '0));
endmodule

// File: rtl/chan_enable_ctrl.sv
// Channel request-enable block: address decode, two command decoders,
// enable mask and registered request gate. Reads are combinational.
// Assumes a halfword-addressed port; bus_addr[0] is ignored.
module chan_enable_ctrl
    import chen_pkg::*;
#(
    parameter int unsigned NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [7:0]     bus_addr,
    input  logic [1:0]     bus_be,
    input  logic [15:0]    bus_wdata,
    output logic [15:0]    bus_rdata,
    input  logic [NCH-1:0] hw_req,
    output logic [NCH-1:0] en_out,
    output logic [NCH-1:0] req_out
);
    region_e        rgn;
    logic [1:0]     lane_wr;
    logic           set_vld;
    logic           clr_vld;
    logic [NCH-1:0] set_mask;
    logic [NCH-1:0] clr_mask;
    logic [NCH-1:0] en_q;

    // Map the halfword address to a register region.
    always_comb begin
        if (bus_addr[7:1] == OFS_ENABLE[7:1])   rgn = RGN_ENABLE;
        else if (bus_addr[7:1] == OFS_CMD[7:1]) rgn = RGN_CMD;
        else                                    rgn = RGN_NONE;
    end

    // Qualify write strobes per lane and region.
    always_comb begin
        lane_wr = (bus_wr && rgn == RGN_ENABLE) ? bus_be : 2'b00;
        set_vld = bus_wr && rgn == RGN_CMD && bus_be[0];
        clr_vld = bus_wr && rgn == RGN_CMD && bus_be[1];
    end

    chen_cmd_decode #(.NCH(NCH)) u_set_dec (
        .clk(clk), .rst_n(rst_n), .cmd_vld(set_vld),
        .cmd_byte(bus_wdata[7:0]), .mask(set_mask)
    );

    chen_cmd_decode #(.NCH(NCH)) u_clr_dec (
        .clk(clk), .rst_n(rst_n), .cmd_vld(clr_vld),
        .cmd_byte(bus_wdata[15:8]), .mask(clr_mask)
    );

    chen_enable_reg #(.NCH(NCH)) u_mask (
        .clk(clk), .rst_n(rst_n), .lane_wr(lane_wr), .wdata(bus_wdata),
        .set_mask(set_mask), .clr_mask(clr_mask), .en_q(en_q)
    );

    chen_req_gate #(.NCH(NCH)) u_gate (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .en(en_q), .req_q(req_out)
    );

    // Read mux: only the enable halfword returns data.
    always_comb begin
        bus_rdata = (bus_rd && rgn == RGN_ENABLE) ? 16'(en_q) : 16'h0000;
    end

    assign en_out = en_q;

    p_cmd_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && rgn != RGN_ENABLE) |-> (bus_rdata == 16'h0000));

    p_unmapped_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && rgn == RGN_NONE) |=> $stable(en_q));
endmodule

// File: tb/chan_enable_ctrl_bench.sv
module chan_enable_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [1:0]  bus_be = 2'b00;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic [15:0] hw_req = 16'h0000;
    logic [15:0] en_out;
    logic [15:0] req_out;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_en = 16'h0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_enable_ctrl u_chan_enable_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .hw_req(hw_req), .en_out(en_out), .req_out(req_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One write cycle; returns at the negedge after the update edge.
    task automatic wr(input logic [7:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 2'b00; bus_wdata = 16'h0000;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic check_mask(input string req);
        logic [15:0] v;
        rd(8'h0E, v);
        check(req, v, exp_en);
        check(req, en_out, exp_en);
    endtask

    task automatic t_reset();
        hw_req = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", en_out, 16'h0000);
        check("R8", req_out, 16'h0000);
        hw_req = 16'h0000;
    endtask

    task automatic t_set_single();
        wr(8'h18, 2'b01, 16'h0005); exp_en = 16'h0020; check_mask("R1");
        wr(8'h18, 2'b01, 16'h000F); exp_en = 16'h8020; check_mask("R1");
        wr(8'h18, 2'b01, 16'h0000); exp_en = 16'h8021; check_mask("R1");
    endtask

    task automatic t_clear_single();
        wr(8'h18, 2'b10, 16'h0F00); exp_en = 16'h0021; check_mask("R2");
        wr(8'h18, 2'b10, 16'h0000); exp_en = 16'h0020; check_mask("R2");
    endtask

    task automatic t_reserved();
        wr(8'h18, 2'b01, 16'h0010); check_mask("R3");
        wr(8'h18, 2'b10, 16'h3F00); check_mask("R3");
        wr(8'h18, 2'b10, 16'h2500); check_mask("R3");
    endtask

    task automatic t_global();
        wr(8'h18, 2'b01, 16'h0040); exp_en = 16'hFFFF; check_mask("R4");
        wr(8'h18, 2'b10, 16'h7F00); exp_en = 16'h0000; check_mask("R5");
    endtask

    task automatic t_top_bit();
        wr(8'h18, 2'b01, 16'h0085); exp_en = 16'h0020; check_mask("R7");
        wr(8'h18, 2'b01, 16'h0090); check_mask("R7");
        wr(8'h18, 2'b10, 16'h8500); exp_en = 16'h0000; check_mask("R7");
    endtask

    task automatic t_reads();
        logic [15:0] v;
        wr(8'h0E, 2'b11, 16'hA5C3); exp_en = 16'hA5C3;
        rd(8'h18, v); check("R6", v, 16'h0000);
        rd(8'h19, v); check("R6", v, 16'h0000);
        rd(8'h40, v); check("R6", v, 16'h0000);
    endtask

    task automatic t_direct();
        wr(8'h0E, 2'b01, 16'hFF12); exp_en = 16'hA512; check_mask("R11");
        wr(8'h0F, 2'b10, 16'h3477); exp_en = 16'h3412; check_mask("R11");
    endtask

    task automatic t_unmapped();
        wr(8'h20, 2'b11, 16'hFFFF); check_mask("R12");
        wr(8'h1A, 2'b11, 16'h4040); check_mask("R12");
        wr(8'h0E, 2'b00, 16'hFFFF); check_mask("R12");
    endtask

    task automatic t_clear_wins();
        wr(8'h18, 2'b01, 16'h0040); exp_en = 16'hFFFF;
        wr(8'h18, 2'b11, 16'h0303); exp_en = 16'hFFF7; check_mask("R9");
        wr(8'h18, 2'b11, 16'h0205); exp_en = 16'hFFF3; check_mask("R9");
        wr(8'h18, 2'b11, 16'h4040); exp_en = 16'h0000; check_mask("R9");
    endtask

    task automatic t_gate();
        hw_req = 16'hFFFF;
        wr(8'h0E, 2'b11, 16'h00F0); exp_en = 16'h00F0;
        @(negedge clk);
        check("R10", req_out, 16'h00F0);
        hw_req = 16'h0F3C;
        @(negedge clk);
        check("R10", req_out, 16'h0030);
        wr(8'h18, 2'b10, 16'h4000); exp_en = 16'h0000;
        @(negedge clk);
        check("R10", req_out, 16'h0000);
        hw_req = 16'h0000;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_set_single();
        t_clear_single();
        t_reserved();
        t_global();
        t_top_bit();
        t_reads();
        t_direct();
        t_unmapped();
        t_clear_wins();
        t_gate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule